// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits between the byte-latch stage of a parallel nonvolatile memory's page write controller and its page buffer. Every latched host write (a 13-bit address and an 8-bit byte) is shown to the sequencer as a one-cycle strobe. The sequencer looks for two fixed multi-write command codes. A three-write code turns write protection on and also opens the current load window for real data. A six-write code turns protection off. Command bytes never reach the buffer. When protection is off, a code that is started but not finished is handed back to the buffer as ordinary data.

The sequencer drives a store qualifier, with the address and byte to store, and a programming-timer start request. The page controller raises a load-timeout pulse when the byte-load window lapses and a program-done pulse when the write cycle ends. A change to the protect state takes effect only on that program-done pulse. A protected write that lacks the unlock prefix is dropped. The timer is still started for it, so the host sees a normal busy period. The protect flag resets to a parameter value, which stands in for a state that survives power loss.

Top module: `swp_sequencer`

## Requirements
- R1: After reset `protOn` equals the `PROT_RESET` parameter (default 0), and `storeStb` and `timerStart` are low.
- R2: While unprotected, a write that is not part of a command code is stored exactly once, with the same address and byte. Stores come out in arrival order, one cycle after the write strobe.
- R3: The enable code is 0xAA at 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555. None of its bytes is stored. `protOn` goes to 1 on the next `progDone`, even when no data follows the code in that window.
- R4: The disable code is 0xAA at 0x1555, 0x55 at 0x0AAA, 0x80 at 0x1555, 0xAA at 0x1555, 0x55 at 0x0AAA, 0x20 at 0x1555. None of its bytes is stored, and `protOn` goes to 0 on the next `progDone`.
- R5: Once a code completes, every later write in the same load window is stored, including while protected.
- R6: While protected, a write without the prefix is not stored, but `timerStart` still pulses at the end of its load window.
- R7: While unprotected, a write that breaks a partial code releases the held code bytes in their original order, then stores the breaking write. If the breaking write is 0xAA at 0x1555, it is not stored and instead begins a new code.
- R8: While unprotected, a load timeout during a partial code releases the held bytes to the buffer before `timerStart` pulses. `storeStb` and `timerStart` are never high in the same cycle.
- R9: While protected, the bytes of a broken or unfinished partial code are discarded and never stored.
- R10: At a load timeout, `timerStart` pulses for exactly one cycle if the window saw at least one write. It stays low for a window with no writes.
- R11: `protOn` changes only in the cycle after a `progDone` pulse.
- R12: After a code completes, code recognition is suspended until the window closes, so bytes that match code values are stored as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | One-cycle strobe for a latched host write |
| wrAddr | input | ADDR_W | Address of the latched write |
| wrData | input | DATA_W | Byte of the latched write |
| loadTimeout | input | 1 | Byte-load window has lapsed; the burst is closed |
| progDone | input | 1 | Programming cycle has finished |
| protOn | output | 1 | Current write-protect state |
| storeStb | output | 1 | Store `storeData` at `storeAddr` into the page buffer |
| storeAddr | output | ADDR_W | Address to store |
| storeData | output | DATA_W | Byte to store |
| timerStart | output | 1 | One-cycle request to start the programming timer |

## Verification
Some properties are checked on every cycle. `protOn` moves only after a program-done pulse. The timer request is a single-cycle pulse. The replay of held bytes happens only while unprotected and never reads past the held count. A store and a timer request never share a cycle.

Other properties only the bench's scenarios can show. These are the exact contents and order of the stored bytes, the discarding of command bytes, the restart of a code inside a broken one, and the deferred effect of each code. The bench shows them by comparing the full event log of every load window against an independent model, over directed windows and random mixes of data writes, code fragments and near-miss bytes.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // The code length is fixed behaviour: at most five bytes are held
  // before the final byte of the longest code arrives.
  localparam int HOLD_SLOTS = 5;
  localparam int SLOT_IDX_W = 3;

  typedef enum logic [1:0] {SR_ADV, SR_ENABLE, SR_DISABLE, SR_BREAK} seqResT;
  typedef enum logic [1:0] {M_RUN, M_DRAIN, M_FINISH} modeT;
  typedef enum logic [1:0] {E_TIMER, E_PEND, E_RESTART} endActT;

  typedef struct packed {
    logic                  passNow;
    logic                  holdWr;
    logic [SLOT_IDX_W-1:0] holdIdx;
    logic                  emitSlot;
    logic [SLOT_IDX_W-1:0] emitIdx;
    logic                  pendWr;
    logic                  emitPend;
    logic                  moveToSlot0;
  } seqStrobeT;

endpackage

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 'h1555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 'h0AAA,
  parameter logic PROT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  input  logic              progDone,
  output seqStrobeT         st,
  output logic              protOn,
  output logic              timerStart
);

  localparam logic [DATA_W-1:0] CODE_OPEN   = 'hAA;
  localparam logic [DATA_W-1:0] CODE_KEY    = 'h55;
  localparam logic [DATA_W-1:0] CODE_LOCK   = 'hA0;
  localparam logic [DATA_W-1:0] CODE_EXT    = 'h80;
  localparam logic [DATA_W-1:0] CODE_UNLOCK = 'h20;
  localparam logic [SLOT_IDX_W-1:0] LAST_STEP = SLOT_IDX_W'(HOLD_SLOTS);

  modeT   modeQ, modeD;
  endActT endActQ, endActD;
  logic [SLOT_IDX_W-1:0] stepQ, stepD, drainIdxQ, drainIdxD, drainCntQ, drainCntD;
  logic unlockQ, unlockD, activeQ, activeD, protQ, protD;
  logic pendEnQ, pendEnD, pendDisQ, pendDisD, timerQ, timerD;
  logic restart;
  seqResT res;

  function automatic seqResT classify(input logic [SLOT_IDX_W-1:0] step,
                                      input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d);
    logic onA, onB;
    onA = (a == CMD_ADDR_A);
    onB = (a == CMD_ADDR_B);
    classify = SR_BREAK;
    case (step)
      3'd0, 3'd3: if (onA && d == CODE_OPEN) classify = SR_ADV;
      3'd1, 3'd4: if (onB && d == CODE_KEY) classify = SR_ADV;
      3'd2: begin
        if (onA && d == CODE_LOCK) classify = SR_ENABLE;
        else if (onA && d == CODE_EXT) classify = SR_ADV;
      end
      3'd5: if (onA && d == CODE_UNLOCK) classify = SR_DISABLE;
      default: classify = SR_BREAK;
    endcase
  endfunction

  always_comb begin
    modeD = modeQ;  endActD = endActQ;
    stepD = stepQ;  drainIdxD = drainIdxQ;  drainCntD = drainCntQ;
    unlockD = unlockQ;  activeD = activeQ;  protD = protQ;
    pendEnD = pendEnQ;  pendDisD = pendDisQ;  timerD = 1'b0;
    st = '0;
    res = classify(stepQ, wrAddr, wrData);
    restart = (wrAddr == CMD_ADDR_A) && (wrData == CODE_OPEN);
    case (modeQ)
      M_RUN: begin
        if (wrStb) begin
          activeD = 1'b1;
          if (unlockQ) st.passNow = 1'b1;
          else begin
            case (res)
              SR_ADV: begin
                st.holdWr = 1'b1;  st.holdIdx = stepQ;  stepD = stepQ + 1'b1;
              end
              SR_ENABLE: begin
                stepD = '0;  unlockD = 1'b1;  pendEnD = 1'b1;  pendDisD = 1'b0;
              end
              SR_DISABLE: begin
                stepD = '0;  unlockD = 1'b1;  pendDisD = 1'b1;  pendEnD = 1'b0;
              end
              default: begin
                if (protQ) begin
                  if (restart) begin
                    st.holdWr = 1'b1;  st.holdIdx = '0;  stepD = 3'd1;
                  end else stepD = '0;
                end else if (stepQ == '0) st.passNow = 1'b1;
                else begin
                  st.pendWr = 1'b1;  drainCntD = stepQ;  drainIdxD = '0;
                  endActD = restart ? E_RESTART : E_PEND;
                  modeD = M_DRAIN;  stepD = '0;
                end
              end
            endcase
          end
        end else if (loadTimeout) begin
          if (!protQ && stepQ != '0) begin
            drainCntD = stepQ;  drainIdxD = '0;  endActD = E_TIMER;
            modeD = M_DRAIN;  stepD = '0;
          end else begin
            timerD = activeQ;  stepD = '0;  unlockD = 1'b0;  activeD = 1'b0;
          end
        end
      end
      M_DRAIN: begin
        st.emitSlot = 1'b1;  st.emitIdx = drainIdxQ;
        drainIdxD = drainIdxQ + 1'b1;
        if (drainIdxQ == drainCntQ - 1'b1) modeD = M_FINISH;
      end
      default: begin
        modeD = M_RUN;
        case (endActQ)
          E_PEND:    st.emitPend = 1'b1;
          E_RESTART: begin st.moveToSlot0 = 1'b1;  stepD = 3'd1; end
          default: begin
            timerD = activeQ;  unlockD = 1'b0;  activeD = 1'b0;
          end
        endcase
      end
    endcase
    if (progDone) begin
      if (pendEnQ) protD = 1'b1;
      else if (pendDisQ) protD = 1'b0;
      pendEnD = 1'b0;  pendDisD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= M_RUN;  endActQ <= E_TIMER;
      stepQ <= '0;  drainIdxQ <= '0;  drainCntQ <= '0;
      unlockQ <= 1'b0;  activeQ <= 1'b0;  protQ <= PROT_RESET;
      pendEnQ <= 1'b0;  pendDisQ <= 1'b0;  timerQ <= 1'b0;
    end else begin
      modeQ <= modeD;  endActQ <= endActD;
      stepQ <= stepD;  drainIdxQ <= drainIdxD;  drainCntQ <= drainCntD;
      unlockQ <= unlockD;  activeQ <= activeD;  protQ <= protD;
      pendEnQ <= pendEnD;  pendDisQ <= pendDisD;  timerQ <= timerD;
    end
  end

  assign protOn = protQ;
  assign timerStart = timerQ;

  // R11
  prot_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protQ != $past(protQ)) |-> $past(progDone));
  // R10
  timer_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerQ |=> !timerQ);
  // R9
  no_replay_when_protected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != M_RUN) |-> !protQ);
  // R8
  replay_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == M_DRAIN) |-> (drainIdxQ < drainCntQ));
  // R7
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepQ <= LAST_STEP);

endmodule

// File: rtl/swp_datapath.sv
module swp_datapath
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         st,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              storeStb,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData
);

  logic [ADDR_W-1:0] slotA [HOLD_SLOTS];
  logic [DATA_W-1:0] slotD [HOLD_SLOTS];
  logic [ADDR_W-1:0] pendA;
  logic [DATA_W-1:0] pendD;
  logic storeStbQ;

  always_ff @(posedge clk) begin
    for (int i = 0; i < HOLD_SLOTS; i++) begin
      if (st.holdWr && st.holdIdx == SLOT_IDX_W'(i)) begin
        slotA[i] <= wrAddr;  slotD[i] <= wrData;
      end else if (st.moveToSlot0 && i == 0) begin
        slotA[i] <= pendA;  slotD[i] <= pendD;
      end
    end
    if (st.pendWr) begin
      pendA <= wrAddr;  pendD <= wrData;
    end
    if (st.passNow) begin
      storeAddr <= wrAddr;  storeData <= wrData;
    end else if (st.emitSlot) begin
      storeAddr <= slotA[st.emitIdx];  storeData <= slotD[st.emitIdx];
    end else if (st.emitPend) begin
      storeAddr <= pendA;  storeData <= pendD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) storeStbQ <= 1'b0;
    else storeStbQ <= st.passNow | st.emitSlot | st.emitPend;
  end

  assign storeStb = storeStbQ;

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 'h1555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 'h0AAA,
  parameter logic PROT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  input  logic              progDone,
  output logic              protOn,
  output logic              storeStb,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData,
  output logic              timerStart
);

  seqStrobeT st;

  swp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR_A(CMD_ADDR_A),
    .CMD_ADDR_B(CMD_ADDR_B), .PROT_RESET(PROT_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .loadTimeout(loadTimeout), .progDone(progDone), .st(st),
    .protOn(protOn), .timerStart(timerStart)
  );

  swp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrAddr(wrAddr), .wrData(wrData),
    .storeStb(storeStb), .storeAddr(storeAddr), .storeData(storeData)
  );

  // R8
  store_timer_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeStb && timerStart));

endmodule

// File: tb/swp_sequencer_test.sv
`timescale 1ns/1ps
module swp_sequencer_test;

  localparam logic [12:0] AK = 13'h1555;
  localparam logic [12:0] BK = 13'h0AAA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0, loadTimeout = 1'b0, progDone = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic protOn, storeStb, timerStart;
  logic [12:0] storeAddr;
  logic [7:0]  storeData;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  swp_sequencer uut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .loadTimeout(loadTimeout), .progDone(progDone), .protOn(protOn),
    .storeStb(storeStb), .storeAddr(storeAddr), .storeData(storeData),
    .timerStart(timerStart)
  );

  // event log: {1,addr,data} for a store, all zero for a timer request
  logic [21:0] expEv [64];
  logic [21:0] gotEv [64];
  int expN = 0, gotN = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (storeStb && gotN < 64) begin gotEv[gotN] = {1'b1, storeAddr, storeData}; gotN++; end
      if (timerStart && gotN < 64) begin gotEv[gotN] = 22'd0; gotN++; end
    end
  end

  // burst under construction
  logic [12:0] bA [48];
  logic [7:0]  bD [48];
  int bN = 0;

  // model state, from the requirements
  int mStep = 0;
  bit mUnl = 0, mAct = 0, mProt = 0, mPEn = 0, mPDis = 0, mTimer = 0;
  logic [12:0] mHA [6];
  logic [7:0]  mHD [6];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int mClass(input int step, input logic [12:0] a, input logic [7:0] d);
    logic [12:0] ca [6];
    logic [7:0]  cd [6];
    ca = '{AK, BK, AK, AK, BK, AK};
    cd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    if (step == 2 && a == AK && d == 8'hA0) return 1;
    if (a == ca[step] && d == cd[step]) return (step == 5) ? 2 : 0;
    return 3;
  endfunction

  task automatic expStore(input logic [12:0] a, input logic [7:0] d);
    expEv[expN] = {1'b1, a, d}; expN++;
  endtask

  task automatic mWrite(input logic [12:0] a, input logic [7:0] d);
    int r;
    bit first;
    mAct = 1;
    if (mUnl) begin expStore(a, d); return; end
    r = mClass(mStep, a, d);
    first = (a == AK && d == 8'hAA);
    if (r == 0) begin mHA[mStep] = a; mHD[mStep] = d; mStep++; end
    else if (r == 1) begin mStep = 0; mUnl = 1; mPEn = 1; mPDis = 0; end
    else if (r == 2) begin mStep = 0; mUnl = 1; mPDis = 1; mPEn = 0; end
    else if (mProt) begin
      if (first) begin mHA[0] = a; mHD[0] = d; mStep = 1; end else mStep = 0;
    end else if (mStep == 0) expStore(a, d);
    else begin
      for (int i = 0; i < mStep; i++) expStore(mHA[i], mHD[i]);
      if (first) begin mHA[0] = a; mHD[0] = d; mStep = 1; end
      else begin expStore(a, d); mStep = 0; end
    end
  endtask

  task automatic mClose();
    if (!mProt && mStep != 0)
      for (int i = 0; i < mStep; i++) expStore(mHA[i], mHD[i]);
    mTimer = mAct;
    if (mAct) begin expEv[expN] = 22'd0; expN++; end
    mStep = 0; mUnl = 0; mAct = 0;
  endtask

  task automatic addW(input logic [12:0] a, input logic [7:0] d);
    bA[bN] = a; bD[bN] = d; bN++;
  endtask

  task automatic addEnable();
    addW(AK, 8'hAA); addW(BK, 8'h55); addW(AK, 8'hA0);
  endtask

  task automatic addDisable();
    addW(AK, 8'hAA); addW(BK, 8'h55); addW(AK, 8'h80);
    addW(AK, 8'hAA); addW(BK, 8'h55); addW(AK, 8'h20);
  endtask

  task automatic pulseIn(input int which);
    @(negedge clk);
    if (which == 0) wrStb = 1'b1; else if (which == 1) loadTimeout = 1'b1; else progDone = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; loadTimeout = 1'b0; progDone = 1'b0;
  endtask

  task automatic runBurst(input string tag);
    expN = 0; gotN = 0;
    for (int i = 0; i < bN; i++) begin
      mWrite(bA[i], bD[i]);
      wrAddr = bA[i]; wrData = bD[i];
      pulseIn(0);
      repeat (9) @(negedge clk);
    end
    mClose();
    pulseIn(1);
    repeat (12) @(negedge clk);
    chk(gotN == expN, {tag, " event count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++)
      chk(gotEv[i] == expEv[i], {tag, " event"}, gotEv[i], expEv[i]);
    // R11: no change before the programming cycle ends
    chk(protOn == mProt, {tag, " R11 protect before done"}, protOn, mProt);
    if (mTimer) begin
      pulseIn(2);
      if (mPEn) mProt = 1; else if (mPDis) mProt = 0;
      mPEn = 0; mPDis = 0;
      repeat (2) @(negedge clk);
      chk(protOn == mProt, {tag, " protect after done"}, protOn, mProt);
    end
    bN = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1
    chk(protOn == 1'b0, "R1 protOn", protOn, 0);
    chk(storeStb == 1'b0, "R1 storeStb", storeStb, 0);
    chk(timerStart == 1'b0, "R1 timerStart", timerStart, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(protOn == 1'b0 && storeStb == 1'b0, "R1 after release", {protOn, storeStb}, 0);

    addW(13'h0100, 8'h11); addW(AK, 8'h12); addW(13'h1FFF, 8'hFE);
    runBurst("R2 plain data");
    addEnable();
    runBurst("R3 enable only");
    addW(13'h0200, 8'h5A); addW(13'h0201, 8'hA5);
    runBurst("R6 blocked write");
    addEnable(); addW(13'h0040, 8'h01); addW(13'h0041, 8'h02); addW(13'h007F, 8'h03);
    runBurst("R5 prefixed write");
    addW(AK, 8'hAA); addW(BK, 8'h55); addW(13'h0040, 8'h33);
    runBurst("R9 broken code");
    addEnable(); addW(AK, 8'hAA); addW(BK, 8'h55); addW(AK, 8'hA0);
    runBurst("R12 codes as data");
    addDisable(); addW(13'h0300, 8'h77);
    runBurst("R4 disable");
    addW(AK, 8'hAA); addW(BK, 8'h55); addW(13'h0100, 8'h77);
    runBurst("R7 release");
    addW(AK, 8'hAA); addW(BK, 8'h55); addW(AK, 8'hAA); addW(13'h0010, 8'h42);
    runBurst("R7 restart");
    addW(AK, 8'hAA); addW(BK, 8'h55); addW(AK, 8'h80);
    runBurst("R8 timeout release");
    runBurst("R10 empty window");

    for (int b = 0; b < 60; b++) begin
      int items;
      items = $urandom_range(0, 6);
      for (int k = 0; k < items; k++) begin
        case ($urandom_range(0, 11))
          4: addW(AK, 8'hAA);
          5: addW(BK, 8'h55);
          6: addW(AK, 8'hA0);
          7: addW(AK, 8'h80);
          8: addW(AK, 8'h20);
          9: addEnable();
          10: addDisable();
          11: addW(BK, 8'hAA);
          default: addW(13'($urandom_range(0, 8191)), 8'($urandom_range(0, 255)));
        endcase
      end
      runBurst("R2 random mix");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule